// File: doc/BRIEF.md
# Dual-rail constant-weight lookup ROM

This block is a small read-only lookup table of eight 8-bit words whose contents are fixed by a parameter. Each logical bit leaves the block as a complementary pair of physical lines, so any word drives exactly half of the sixteen output lines high. The Hamming weight of the bus therefore does not depend on the stored data.

A read starts when the strobe is sampled high. The address is captured with that strobe. The block then spends one cycle with the whole bus forced to zero (the spacer). In the next cycle it presents the dual-rail word, with a one-cycle valid flag. Every read passes through this neutral code, so the bus never moves directly from one data word to another.

A decoded 8-bit word is taken from the true rails. A sticky flag records any malformed rail pair. The sequencer has three named states:
- IDLE: waiting, with the last word held on the bus.
- SPACER: the bus is all zero.
- EVAL: the new word is on the bus and valid is high.

Its transitions are:
- IDLE→SPACER on a strobe.
- IDLE→IDLE with no strobe.
- SPACER→EVAL always.
- EVAL→SPACER on a strobe, which gives back-to-back reads.
- EVAL→IDLE with no strobe.

Top module: `dr_lut_rom`

## Requirements
- R1: After reset the rail bus is all zero, the decoded word is 0, and both the valid flag and the error flag are low.
- R2: A strobe sampled in IDLE makes the next cycle a spacer cycle, with all 16 rail lines low and valid low. The cycle after that is the evaluate cycle.
- R3: The valid flag is high in the evaluate cycle only, and never for two cycles in a row.
- R4: In the evaluate cycle, rail pair i occupies bits 2i+1 (true rail) and 2i (false rail). A logic 1 is shown as 10 and a logic 0 as 01. The word shown is CONTENT[a], where a is the address sampled together with the accepted strobe, decoded through eight one-hot select lines.
- R5: In the evaluate cycle exactly 8 of the 16 rail lines are high, whatever the stored value.
- R6: Bit i of the decoded word equals rail bit 2i+1 of the evaluated word. The decoded word changes only on entry to the evaluate cycle and holds through spacer and idle cycles.
- R7: After an evaluate cycle with no new strobe, the bus keeps the last evaluated word (still weight 8) until the next spacer.
- R8: A strobe sampled in the evaluate cycle is accepted. Its address is captured, and the next cycle is a spacer.
- R9: A strobe or address change during a spacer cycle is ignored. The following evaluate cycle shows the word for the earlier captured address.
- R10: The error flag is set at the clock edge after any rail pair shows 11, or any pair shows 00 during an evaluate cycle. It then stays set until reset. With parameter-derived contents it never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read strobe |
| rd_addr | input | ADDR_W (3) | Word address, captured with an accepted strobe |
| rail_bus | output | 2*WIDTH (16) | Dual-rail data lines, pair i at bits 2i+1 (true) and 2i (false) |
| word_out | output | WIDTH (8) | Logical word decoded from the true rails |
| word_valid | output | 1 | High for the single evaluate cycle |
| enc_err | output | 1 | Sticky flag for a malformed rail pair |

## Verification
The evaluate cycle and the acceptance of a new strobe can fall in the same cycle. The bench provokes this by raising the strobe with a fresh address exactly when valid is high. It then judges that the following cycle drops back to an all-zero spacer and that the old decoded word is still held there. It also judges that the next evaluate cycle shows the new word at weight 8.

The spacer cycle can likewise meet a strobe. The bench drives a strobe with a different address there and confirms that the earlier captured address wins.

// File: rtl/dr_lut_pkg.sv
package dr_lut_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SPACER = 2'd1,
        ST_EVAL   = 2'd2
    } rd_state_t;

    // Rail pair for one logical bit: {true, false}
    function automatic logic [1:0] rail_pair(input logic bit_val);
        return bit_val ? 2'b10 : 2'b01;
    endfunction

endpackage

// File: rtl/dr_addr_decode.sv
module dr_addr_decode #(
    parameter int DEPTH  = 8,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DEPTH-1:0]  sel
);
    // One select line per word: the AND of that word's address minterm
    for (genvar w = 0; w < DEPTH; w++) begin : g_minterm
        localparam logic [ADDR_W-1:0] CODE = ADDR_W'(w);
        assign sel[w] = &(addr ~^ CODE);
    end
endmodule

// File: rtl/dr_rail_array.sv
module dr_rail_array
    import dr_lut_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    parameter logic [DEPTH-1:0][WIDTH-1:0] CONTENT = '0
) (
    input  logic [DEPTH-1:0]       sel,
    output logic [2*WIDTH-1:0]     rail_word
);
    logic [DEPTH-1:0][2*WIDTH-1:0] image;

    // Dual-rail image is fixed at elaboration from the logical bytes
    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            assign image[w][2*b+1:2*b] = rail_pair(CONTENT[w][b]);
        end
    end

    // Wired-OR of the selected row
    always_comb begin
        rail_word = '0;
        for (int w = 0; w < DEPTH; w++) begin
            if (sel[w]) rail_word = rail_word | image[w];
        end
    end
endmodule

// File: rtl/dr_rail_check.sv
module dr_rail_check #(
    parameter int WIDTH = 8
) (
    input  logic [2*WIDTH-1:0] rail_bus,
    input  logic               in_eval,
    output logic               bad
);
    logic [WIDTH-1:0] pair_bad;

    for (genvar b = 0; b < WIDTH; b++) begin : g_pair
        logic both_hi;
        logic both_lo;
        assign both_hi     = rail_bus[2*b+1] & rail_bus[2*b];
        assign both_lo     = ~(rail_bus[2*b+1] | rail_bus[2*b]);
        assign pair_bad[b] = both_hi | (in_eval & both_lo);
    end

    assign bad = |pair_bad;
endmodule

// File: rtl/dr_lut_rom.sv
module dr_lut_rom
    import dr_lut_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int WIDTH  = 8,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter logic [DEPTH-1:0][WIDTH-1:0] CONTENT =
        {8'hC3, 8'h5A, 8'h80, 8'h01, 8'h3C, 8'hA5, 8'hFF, 8'h00}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_req,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [2*WIDTH-1:0]  rail_bus,
    output logic [WIDTH-1:0]    word_out,
    output logic                word_valid,
    output logic                enc_err
);
    localparam int RAIL_W = 2 * WIDTH;

    rd_state_t          state_q, state_d;
    logic [ADDR_W-1:0]  addr_q;
    logic [RAIL_W-1:0]  rail_q;
    logic [RAIL_W-1:0]  rail_word;
    logic [DEPTH-1:0]   sel;
    logic               err_q;
    logic               pair_bad;
    logic               accept;

    // Row select and dual-rail storage
    dr_addr_decode #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_dec (
        .addr (addr_q),
        .sel  (sel)
    );

    dr_rail_array #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CONTENT(CONTENT)) u_arr (
        .sel       (sel),
        .rail_word (rail_word)
    );

    dr_rail_check #(.WIDTH(WIDTH)) u_chk_pairs (
        .rail_bus (rail_bus),
        .in_eval  (state_q == ST_EVAL),
        .bad      (pair_bad)
    );

    // A strobe is taken in IDLE or in EVAL; a spacer cycle ignores it
    assign accept = rd_req && (state_q != ST_SPACER);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = rd_req ? ST_SPACER : ST_IDLE;
            ST_SPACER: state_d = ST_EVAL;
            ST_EVAL:   state_d = rd_req ? ST_SPACER : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output-side registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            rail_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (accept) addr_q <= rd_addr;
            if (state_q == ST_SPACER) rail_q <= rail_word;
            err_q <= err_q | pair_bad;
        end
    end

    // Bus is forced to the spacer code while in SPACER
    always_comb begin
        unique case (state_q)
            ST_SPACER: rail_bus = '0;
            default:   rail_bus = rail_q;
        endcase
    end

    assign word_valid = (state_q == ST_EVAL);
    assign enc_err    = err_q;

    for (genvar b = 0; b < WIDTH; b++) begin : g_true
        assign word_out[b] = rail_q[2*b+1];
    end
endmodule

// File: rtl/dr_lut_rom_chk.sv
module dr_lut_rom_chk
    import dr_lut_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               rd_req,
    input logic [2*WIDTH-1:0] rail_bus,
    input logic [WIDTH-1:0]   word_out,
    input logic               word_valid,
    input logic               enc_err,
    input rd_state_t          state,
    input logic [DEPTH-1:0]   sel
);
    assert_spacer_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && rd_req) |=> (rail_bus == '0 && !word_valid));

    assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    assert_onehot_select_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel) == 1);

    assert_const_weight_R5: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> ($countones(rail_bus) == WIDTH));

    assert_word_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_valid && $past(rst_n)) |-> $stable(word_out));

    assert_back_to_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EVAL && rd_req) |=> (state == ST_SPACER));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        enc_err |=> enc_err);
endmodule

bind dr_lut_rom dr_lut_rom_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .rail_bus   (rail_bus),
    .word_out   (word_out),
    .word_valid (word_valid),
    .enc_err    (enc_err),
    .state      (state_q),
    .sel        (sel)
);

// File: tb/dr_lut_rom_bench.sv
`timescale 1ns/1ps
module dr_lut_rom_bench;
    localparam int DEPTH = 8;
    localparam int WIDTH = 8;
    localparam logic [DEPTH-1:0][WIDTH-1:0] TABLE =
        {8'hC3, 8'h5A, 8'h80, 8'h01, 8'h3C, 8'hA5, 8'hFF, 8'h00};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req = 1'b0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rail_bus;
    logic [7:0]  word_out;
    logic        word_valid;
    logic        enc_err;

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_word = 8'h00;

    always #10 clk = ~clk;

    dr_lut_rom #(.DEPTH(DEPTH), .WIDTH(WIDTH), .CONTENT(TABLE)) u_dr_lut_rom (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
        .rail_bus(rail_bus), .word_out(word_out), .word_valid(word_valid),
        .enc_err(enc_err)
    );

    function automatic logic [15:0] to_rails(input logic [7:0] v);
        logic [15:0] r;
        for (int b = 0; b < 8; b++) r[2*b +: 2] = v[b] ? 2'b10 : 2'b01;
        return r;
    endfunction

    function automatic int popcnt(input logic [15:0] v);
        int n = 0;
        for (int b = 0; b < 16; b++) n += int'(v[b]);
        return n;
    endfunction

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_spacer();
        check(rail_bus == 16'h0, "R2 spacer bus", 32'(rail_bus), 0);
        check(!word_valid, "R2 spacer valid", 32'(word_valid), 0);
        check(word_out == exp_word, "R6 word held in spacer", 32'(word_out), 32'(exp_word));
    endtask

    task automatic check_eval(input logic [2:0] a);
        exp_word = TABLE[a];
        check(word_valid, "R3 valid in eval", 32'(word_valid), 1);
        check(rail_bus == to_rails(exp_word), "R4 eval rails", 32'(rail_bus), 32'(to_rails(exp_word)));
        check(popcnt(rail_bus) == 8, "R5 weight", 32'(popcnt(rail_bus)), 8);
        check(word_out == exp_word, "R6 decoded word", 32'(word_out), 32'(exp_word));
    endtask

    task automatic check_idle();
        check(!word_valid, "R3 valid drops", 32'(word_valid), 0);
        check(rail_bus == to_rails(exp_word), "R7 idle hold", 32'(rail_bus), 32'(to_rails(exp_word)));
        check(word_out == exp_word, "R6 word held in idle", 32'(word_out), 32'(exp_word));
    endtask

    // Single read; when poke is set a stray strobe hits the spacer cycle (R9)
    task automatic read_one(input logic [2:0] a, input logic poke);
        @(negedge clk); rd_req = 1'b1; rd_addr = a;
        @(negedge clk); check_spacer();
        rd_req = poke; rd_addr = ~a;
        @(negedge clk); check_eval(a);
        rd_req = 1'b0;
        @(negedge clk); check_idle();
    endtask

    // Two reads with the second strobe landing in the evaluate cycle (R8)
    task automatic read_pair(input logic [2:0] a0, input logic [2:0] a1);
        @(negedge clk); rd_req = 1'b1; rd_addr = a0;
        @(negedge clk); check_spacer(); rd_req = 1'b0;
        @(negedge clk); check_eval(a0); rd_req = 1'b1; rd_addr = a1;
        @(negedge clk);
        check(rail_bus == 16'h0, "R8 spacer after eval strobe", 32'(rail_bus), 0);
        check(word_out == exp_word, "R8 old word kept", 32'(word_out), 32'(exp_word));
        rd_req = 1'b0; rd_addr = ~a1;
        @(negedge clk); check_eval(a1);
        @(negedge clk); check_idle();
    endtask

    initial begin
        int order[8];
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(rail_bus == 16'h0, "R1 reset bus", 32'(rail_bus), 0);
        check(word_out == 8'h0, "R1 reset word", 32'(word_out), 0);
        check(!word_valid && !enc_err, "R1 reset flags", {word_valid, enc_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rail_bus == 16'h0 && !word_valid, "R1 idle after reset", 32'(rail_bus), 0);

        // All addresses in shuffled order
        for (int i = 0; i < 8; i++) order[i] = i;
        for (int i = 7; i > 0; i--) begin
            int j = int'($urandom_range(i, 0));
            int t = order[i]; order[i] = order[j]; order[j] = t;
        end
        for (int i = 0; i < 8; i++) read_one(3'(order[i]), 1'b0);

        // Directed: extreme weights back to back, stray strobe in spacer
        read_pair(3'd0, 3'd1);
        read_one(3'd7, 1'b1);

        // Random mix
        for (int i = 0; i < 20; i++) begin
            if ($urandom_range(1, 0) == 1)
                read_pair(3'($urandom_range(7, 0)), 3'($urandom_range(7, 0)));
            else
                read_one(3'($urandom_range(7, 0)), 1'($urandom_range(1, 0)));
        end

        check(!enc_err, "R10 no encoding error", 32'(enc_err), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule